// File: doc/BRIEF.md
# Dual-Strobe Synchronous Burst SRAM

This block is a cycle-level model of a pipelined synchronous SRAM with four byte lanes and a two-bit burst counter. It is used to exercise and check the access protocol of a host that talks to such a memory. Every control input is sampled on the rising clock edge. Three chip selects gate the block. Two address strobes start accesses: a processor strobe and a controller strobe. A further set of inputs steers the burst and the byte writes. The shared data bus is split into an input word, an output word and a drive enable.

An access can start from either strobe, and the two strobes follow different write timing. A start from the processor strobe is always a read at first. A write, if one follows, lands on the next edge at the captured address. A start from the controller strobe writes in its own cycle whenever the write inputs ask for it. After a start, an advance input steps a two-bit counter through four beats. The low address bits then follow a linear or an interleaved order, chosen by a static order input. A global write overrides the byte masks. The bus is driven only for read data, only while output enable is low, and never while the write inputs signal a write.

Top module: `sbsram_top`

## Requirements
- R1: An access starts only on an edge where the three chip selects are all active (`cs_a_n`=0, `cs_b`=1, `cs_c_n`=0) and a strobe (`pstb_n` or `cstb_n`) is low. A strobe seen while the selects are not all active starts nothing and writes nothing.
- R2: `pstb_n` low has no effect while `cs_a_n` is high. With `cstb_n` high, such an edge leaves a running burst and its read data untouched.
- R3: When `pstb_n` and `cstb_n` are both low with all selects active, the processor strobe wins. The edge is a processor start, and the write inputs are ignored on it.
- R4: A processor start reads the captured address and never writes on its own edge. If the write inputs signal a write on the following edge, the captured address is written with that edge's `dq_in`.
- R5: A controller start (`cstb_n`=0, `pstb_n`=1, all selects active) whose write inputs signal a write writes `dq_in` to the presented address on that same edge. Otherwise it is a read.
- R6: `gw_n`=0 signals a write of all four lanes, whatever `bwe_n` and `bsel_n` are.
- R7: With `gw_n`=1, lane i (`dq_in` bits [8i+7:8i]) is written only if `bwe_n`=0 and `bsel_n[i]`=0. If `bwe_n`=0 but every `bsel_n` bit is 1, or if `bwe_n`=1, there is no write.
- R8: Read data is pipelined. The word read on an edge appears on `dq_out` after that edge and stays there until the next read.
- R9: Each beat with `adv_n`=0 during a burst steps the counter, and the beat reads (or writes) the next address. The upper address bits stay fixed. The low two bits are (start+count) mod 4 when `burst_lin`=1, and start XOR count when `burst_lin`=0. The burst wraps after four beats.
- R10: `dq_oe` is 1 only when the last access was a read and `oe_n`=0. It is 0 after reset.
- R11: `dq_oe` is 0 while the write inputs signal a write, even with `oe_n`=0.
- R12: A strobe edge that starts nothing because the selects are not all active ends the burst. `dq_oe` is then 0 until a new read.
- R13: A burst beat with `adv_n`=1 and no pending first-cycle write is a suspend. Address, counter and `dq_out` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_a_n | input | 1 | First chip select, active low; also gates `pstb_n` |
| cs_b | input | 1 | Second chip select, active high |
| cs_c_n | input | 1 | Third chip select, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-lane byte selects, active low, bit i = lane i |
| oe_n | input | 1 | Output enable, active low |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| addr | input | 6 | Word address |
| dq_in | input | 32 | Data from the bus |
| dq_out | output | 32 | Data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The array is first filled with global-write bursts started by the controller strobe. Bursts in both orders, from unaligned starts and past the wrap, then tell the two orders apart and show where the counter wraps. Processor-started writes are then set beside controller-started writes. Each is read back, which shows whether data lands on the start edge or on the edge after. Byte-select patterns with one lane, two lanes and no lanes, and the same patterns with `bwe_n` high, separate the global-write path from the masked path. Strobe collisions, a processor strobe with the first select high, and strobes with one select dropped check the start priority and deselection. Toggling `oe_n` and the write inputs during reads shows that the bus turns off.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/sbsram_burst_addr.sv
module sbsram_burst_addr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic              step,
  input  logic              lin,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] acc_addr
);
  localparam int CW = 2;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [CW-1:0]     ofs;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (ld) begin
      base_d = addr_in;
      cnt_d  = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (lin) ofs = base_d[CW-1:0] + cnt_d;
    else     ofs = base_d[CW-1:0] ^ cnt_d;
    acc_addr = {base_d[ADDR_W-1:CW], ofs};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (ld || step) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/sbsram_lanes.sv
module sbsram_lanes #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        wmask,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wmask[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sbsram_seq.sv
module sbsram_seq
  import sbsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_a_n,
  input  logic             cs_b,
  input  logic             cs_c_n,
  input  logic             pstb_n,
  input  logic             cstb_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bsel_n,
  output logic             ld,
  output logic             step,
  output logic             rd_en,
  output logic [LANES-1:0] wmask,
  output logic             wr_req,
  output logic             rd_valid,
  output logic             burst_act
);
  logic act_q, act_d;
  logic pf_q, pf_d;
  logic rdv_q, rdv_d;
  logic all_sel, p_eff, p_go, c_go, desel;
  logic [LANES-1:0] lane_sel;
  acc_e acc;

  always_comb begin
    all_sel = !cs_a_n && cs_b && !cs_c_n;
    p_eff   = !pstb_n && !cs_a_n;
    p_go    = all_sel && p_eff;
    c_go    = all_sel && !p_eff && !cstb_n;
    desel   = !all_sel && (p_eff || !cstb_n);
    wr_req  = !gw_n || (!bwe_n && !(&bsel_n));
    if (!gw_n)       lane_sel = '1;
    else if (!bwe_n) lane_sel = ~bsel_n;
    else             lane_sel = '0;
  end

  always_comb begin
    ld    = 1'b0;
    step  = 1'b0;
    acc   = ACC_NONE;
    act_d = act_q;
    pf_d  = pf_q;
    rdv_d = rdv_q;
    if (p_go) begin
      ld    = 1'b1;
      acc   = ACC_READ;
      act_d = 1'b1;
      pf_d  = 1'b1;
    end else if (c_go) begin
      ld    = 1'b1;
      acc   = wr_req ? ACC_WRITE : ACC_READ;
      act_d = 1'b1;
      pf_d  = 1'b0;
    end else if (desel) begin
      act_d = 1'b0;
      pf_d  = 1'b0;
      rdv_d = 1'b0;
    end else if (act_q) begin
      pf_d = 1'b0;
      if (pf_q && wr_req) begin
        acc = ACC_WRITE;
      end else if (!adv_n) begin
        step = 1'b1;
        acc  = wr_req ? ACC_WRITE : ACC_READ;
      end
    end
    if (acc == ACC_READ)  rdv_d = 1'b1;
    if (acc == ACC_WRITE) rdv_d = 1'b0;
  end

  always_comb begin
    rd_en     = (acc == ACC_READ);
    wmask     = (acc == ACC_WRITE) ? lane_sel : '0;
    rd_valid  = rdv_q;
    burst_act = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      pf_q  <= 1'b0;
      rdv_q <= 1'b0;
    end else begin
      act_q <= act_d;
      pf_q  <= pf_d;
      rdv_q <= rdv_d;
    end
  end
endmodule

// File: rtl/sbsram_top.sv
module sbsram_top #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_a_n,
  input  logic                    cs_b,
  input  logic                    cs_c_n,
  input  logic                    pstb_n,
  input  logic                    cstb_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic                    oe_n,
  input  logic                    burst_lin,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  logic rst_s1, rst_q;
  logic ld, step, rd_en, wr_req, rd_valid, burst_act;
  logic [LANES-1:0]  wmask;
  logic [ADDR_W-1:0] acc_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  sbsram_seq #(.LANES(LANES)) u_seq (
    .clk(clk), .rst_n(rst_q),
    .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .ld(ld), .step(step), .rd_en(rd_en), .wmask(wmask),
    .wr_req(wr_req), .rd_valid(rd_valid), .burst_act(burst_act)
  );

  sbsram_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_q), .ld(ld), .step(step),
    .lin(burst_lin), .addr_in(addr), .acc_addr(acc_addr)
  );

  sbsram_lanes #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk(clk), .rst_n(rst_q), .wmask(wmask), .rd_en(rd_en),
    .addr(acc_addr), .wdata(dq_in), .rdata(dq_out)
  );

  always_comb dq_oe = rd_valid && !oe_n && !wr_req;
endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_q,
  input logic             cs_a_n,
  input logic             cs_b,
  input logic             cs_c_n,
  input logic             pstb_n,
  input logic             cstb_n,
  input logic             gw_n,
  input logic             bwe_n,
  input logic [LANES-1:0] bsel_n,
  input logic             oe_n,
  input logic [LANES-1:0] wmask,
  input logic             burst_act,
  input logic             dq_oe
);
  logic all_sel, wr_sig;
  always_comb begin
    all_sel = !cs_a_n && cs_b && !cs_c_n;
    wr_sig  = !gw_n || (!bwe_n && !(&bsel_n));
  end

  p_start_gate_r1: assert property (@(posedge clk) disable iff (!rst_q)
    (!all_sel && !burst_act) |-> (wmask == '0));

  p_pstb_masked_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (cs_a_n && cstb_n && !burst_act) |-> (wmask == '0));

  p_pstb_priority_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (all_sel && !pstb_n && !cstb_n) |-> (wmask == '0));

  p_pfirst_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (all_sel && !pstb_n) |-> (wmask == '0));

  p_cstart_write_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (all_sel && pstb_n && !cstb_n && wr_sig) |-> (wmask != '0));

  p_global_all_r6: assert property (@(posedge clk) disable iff (!rst_q)
    ((wmask != '0) && !gw_n) |-> (&wmask));

  p_lane_subset_r7: assert property (@(posedge clk) disable iff (!rst_q)
    ((wmask != '0) && gw_n) |-> (!bwe_n && ((wmask & bsel_n) == '0)));

  p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_q)
    dq_oe |-> !oe_n);

  p_write_blank_r11: assert property (@(posedge clk) disable iff (!rst_q)
    wr_sig |-> !dq_oe);

  p_deselect_off_r12: assert property (@(posedge clk) disable iff (!rst_q)
    (!all_sel && ((!pstb_n && !cs_a_n) || !cstb_n)) |=> !dq_oe);
endmodule

bind sbsram_top sbsram_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_q(rst_q),
  .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
  .pstb_n(pstb_n), .cstb_n(cstb_n),
  .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n),
  .wmask(wmask), .burst_act(burst_act), .dq_oe(dq_oe)
);

// File: tb/sbsram_top_bench.sv
module sbsram_top_bench;
  localparam int AW    = 6;
  localparam int LN    = 4;
  localparam int LW    = 8;
  localparam int DW    = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cs_a_n, cs_b, cs_c_n, pstb_n, cstb_n, adv_n, gw_n, bwe_n, oe_n, burst_lin;
  logic [LN-1:0] bsel_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_oe;

  sbsram_top #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_sbsram_top (
    .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bsel_n(bsel_n), .oe_n(oe_n), .burst_lin(burst_lin), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R10";

  // reference model state
  logic [DW-1:0] mm [DEPTH];
  bit            m_act, m_pf, m_rdv;
  int            m_base, m_cnt;
  logic [DW-1:0] m_rdata = '0;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  function automatic bit wr_now();
    return !gw_n || (!bwe_n && (bsel_n != '1));
  endfunction

  function automatic int model_addr();
    int lo;
    lo = burst_lin ? ((m_base + m_cnt) & 3) : ((m_base & 3) ^ m_cnt);
    return (m_base & ~3) | lo;
  endfunction

  task automatic m_write(int a);
    for (int l = 0; l < LN; l++) begin
      if (!gw_n || (!bwe_n && !bsel_n[l])) mm[a][l*LW +: LW] = dq_in[l*LW +: LW];
    end
    m_rdv = 1'b0;
  endtask

  task automatic m_read(int a);
    m_rdata = mm[a];
    m_rdv   = 1'b1;
  endtask

  task automatic model_edge();
    bit sel, peff;
    sel  = !cs_a_n && cs_b && !cs_c_n;
    peff = !pstb_n && !cs_a_n;
    if (sel && peff) begin
      m_act = 1; m_pf = 1; m_base = int'(addr); m_cnt = 0;
      m_read(model_addr());
    end else if (sel && !cstb_n) begin
      m_act = 1; m_pf = 0; m_base = int'(addr); m_cnt = 0;
      if (wr_now()) m_write(model_addr());
      else          m_read(model_addr());
    end else if (!sel && (peff || !cstb_n)) begin
      m_act = 0; m_pf = 0; m_rdv = 0;
    end else if (m_act) begin
      if (m_pf && wr_now()) begin
        m_pf = 0;
        m_write(model_addr());
      end else begin
        m_pf = 0;
        if (!adv_n) begin
          m_cnt = (m_cnt + 1) & 3;
          if (wr_now()) m_write(model_addr());
          else          m_read(model_addr());
        end
      end
    end
  endtask

  task automatic compare();
    bit exp_oe;
    exp_oe = m_rdv && !oe_n && !wr_now();
    check(cur_req, {31'd0, dq_oe}, {31'd0, exp_oe}, "dq_oe");
    if (exp_oe) check(cur_req, dq_out, m_rdata, "dq_out");
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic set_idle();
    cs_a_n = 0; cs_b = 1; cs_c_n = 0; pstb_n = 1; cstb_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bsel_n = '1; oe_n = 0; addr = '0; dq_in = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [DW-1:0] held;
    set_idle();
    burst_lin = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R10";
    check("R10", {31'd0, dq_oe}, 32'd0, "dq_oe after reset");
    repeat (3) tick();

    // fill all words with controller-started global-write bursts
    for (int b = 0; b < DEPTH / 4; b++) begin
      for (int k = 0; k < 4; k++) begin
        set_idle();
        if (k == 0) begin cur_req = "R5"; cstb_n = 0; addr = AW'(b * 4); end
        else        begin cur_req = "R6"; adv_n = 0; end
        gw_n = 0; bwe_n = 1; bsel_n = '1;
        dq_in = 32'h5A00_0000 ^ (32'(b * 4 + k) * 32'h0001_0203);
        tick();
      end
    end

    // linear burst from an unaligned start, running past the wrap
    cur_req = "R8"; set_idle(); pstb_n = 0; addr = 6'd6; tick();
    cur_req = "R9";
    for (int k = 0; k < 5; k++) begin set_idle(); adv_n = 0; tick(); end

    // suspend holds data
    cur_req = "R13"; set_idle(); held = m_rdata; tick(); tick();
    check("R13", dq_out, held, "dq_out during suspend");

    // interleaved burst
    burst_lin = 0;
    cur_req = "R9"; set_idle(); cstb_n = 0; addr = 6'd11; tick();
    for (int k = 0; k < 5; k++) begin set_idle(); adv_n = 0; tick(); end
    burst_lin = 1;

    // processor start: write ignored first edge, lands next edge on lanes 0 and 2
    cur_req = "R4"; set_idle(); pstb_n = 0; addr = 6'd16; gw_n = 0; dq_in = 32'hDEAD_BEEF; tick();
    set_idle(); bwe_n = 0; bsel_n = 4'b1010; dq_in = 32'h1122_3344; tick();
    set_idle(); cstb_n = 0; addr = 6'd16; tick();
    check("R4", dq_out, (mm[16]), "readback after processor write");
    set_idle(); tick();

    // strobe collision: processor wins, write ignored
    cur_req = "R3"; set_idle(); pstb_n = 0; cstb_n = 0; gw_n = 0; addr = 6'd20; dq_in = '1; tick();
    set_idle(); tick();
    check("R3", {31'd0, dq_oe}, 32'd1, "read after collision");

    // selects incomplete: nothing written
    cur_req = "R1"; set_idle(); cs_b = 0; cstb_n = 0; gw_n = 0; addr = 6'd24; dq_in = 32'h0BAD_0BAD; tick();
    set_idle(); cs_c_n = 1; cstb_n = 0; gw_n = 0; addr = 6'd25; dq_in = 32'h0BAD_0BAD; tick();
    set_idle(); cstb_n = 0; addr = 6'd24; tick();
    set_idle(); adv_n = 0; tick();

    // processor strobe with first select high: ignored, burst continues
    cur_req = "R2"; held = dq_out;
    set_idle(); cs_a_n = 1; pstb_n = 0; addr = 6'd40; tick();
    check("R2", dq_out, held, "dq_out unchanged");
    check("R2", {31'd0, dq_oe}, 32'd1, "dq_oe unchanged");

    // deselect ends burst
    cur_req = "R12"; set_idle(); cs_a_n = 1; pstb_n = 0; cstb_n = 0; tick();
    set_idle(); tick();
    check("R12", {31'd0, dq_oe}, 32'd0, "dq_oe after deselect");

    // byte masks
    cur_req = "R7"; set_idle(); cstb_n = 0; addr = 6'd32; bwe_n = 1; bsel_n = 4'b0000; dq_in = 32'hFFFF_FFFF; tick();
    set_idle(); cstb_n = 0; addr = 6'd33; bwe_n = 0; bsel_n = 4'b1111; dq_in = 32'hFFFF_FFFF; tick();
    set_idle(); cstb_n = 0; addr = 6'd34; bwe_n = 0; bsel_n = 4'b1001; dq_in = 32'hA1B2_C3D4; tick();
    set_idle(); cstb_n = 0; addr = 6'd35; bwe_n = 0; bsel_n = 4'b0111; dq_in = 32'h7766_5544; tick();
    for (int a = 32; a < 36; a++) begin
      set_idle(); cstb_n = 0; addr = AW'(a); tick();
      set_idle(); tick();
    end

    // output enable gating and write blanking
    cur_req = "R10"; set_idle(); cstb_n = 0; addr = 6'd44; tick();
    set_idle(); oe_n = 1; tick();
    check("R10", {31'd0, dq_oe}, 32'd0, "dq_oe with oe_n high");
    cur_req = "R11"; set_idle(); bwe_n = 0; bsel_n = 4'b0111; #1;
    check("R11", {31'd0, dq_oe}, 32'd0, "dq_oe with byte write asserted");
    set_idle(); gw_n = 0; #1;
    check("R11", {31'd0, dq_oe}, 32'd0, "dq_oe with global write asserted");
    set_idle(); tick();
    check("R11", {31'd0, dq_oe}, 32'd1, "dq_oe restored");

    summary();
  end
endmodule